// File: doc/BRIEF.md
# Mixed-Length Instruction Fetch Aligner

This block sits between a 32-bit instruction memory and the decode stage of a core that runs a mix of 16-bit compressed and 32-bit instructions. It keeps a halfword-aligned fetch PC and reads whole 32-bit words. It delivers one complete instruction at a time with its PC and a compressed flag. An upper halfword that is left over after a fetch is kept in a one-entry buffer. The buffer serves two cases: the second of two compressed instructions packed in one word, and the low half of a 32-bit instruction that runs into the following word. Expansion of compressed instructions to 32 bits happens in a later stage. That stage uses the compressed flag, and the flag also sets the PC step.

The memory side is a request/response pair with no latency. While `mem_req` is high, `mem_addr` carries a word address. The memory answers in the same cycle by raising `mem_rvalid` with `mem_rdata`, or it holds `mem_rvalid` low to add a wait state. The decode side is a valid/ready stream fed from one output register. An instruction transfers on a clock edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the instruction, its PC and its flag stay unchanged. A held output blocks further fetching until it is taken. `stall`, `flush` and the redirect pair are plain control inputs. A redirect has priority over flush, and flush has priority over stall.

Top module: `fetch_aligner`

## Requirements
- R1: After reset, `out_valid` is 0, the buffer is empty and the first request is for the word at address 0. No instruction is presented before a read has been answered with `mem_rvalid`.
- R2: An instruction whose bits [1:0] equal 2'b11 is 32 bits wide. Any other value marks a compressed instruction. For a compressed instruction `out_is16` is 1, `out_instr[15:0]` holds the halfword and `out_instr[31:16]` is zero.
- R3: Instructions are presented in program order. The PC of each one is the previous PC plus 2 after a compressed instruction, or plus 4 after a 32-bit one.
- R4: If one word holds two compressed instructions, the second is issued from the buffered upper halfword, with `mem_req` low in the cycle it is produced.
- R5: A 32-bit instruction at a PC with bit 1 set is presented as {lower halfword of the next word, upper halfword of its own word}.
- R6: Consecutive split 32-bit instructions each take their low half from the upper halfword buffered from the previous read.
- R7: A redirect (`redir_valid` high) discards the buffer and any held output and restarts at `redir_pc` with bit 0 forced to zero. This works for targets that hold a compressed instruction or a split 32-bit instruction.
- R8: While `stall` is high, `mem_req` is 0 and the PC, the buffer contents and the buffer valid bit do not change.
- R9: While `flush` is high, `out_valid` is 0. The buffer and the output register are cleared, so `out_valid` is also 0 in the next cycle. Fetch resumes at the oldest instruction not yet taken, so no instruction is lost or repeated.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_instr`, `out_pc` and `out_is16` stay unchanged.
- R11: `mem_addr` always has bits [1:0] at zero. It is the word holding the PC, or the next word when a buffered low half is being completed. No instruction is produced in a cycle where a needed read gets `mem_rvalid` low.
- R12: When only the first half of a split instruction has been read (first read after a redirect to such a PC), nothing is produced in that cycle. After the redirect, a split target appears one cycle later than a compressed target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Freeze fetch state |
| flush | input | 1 | Drop buffer and held output, refetch oldest untaken instruction |
| redir_valid | input | 1 | Restart fetch at `redir_pc` |
| redir_pc | input | PC_W | Redirect target, halfword aligned |
| mem_req | output | 1 | Read request for `mem_addr` |
| mem_addr | output | PC_W | Word-aligned byte address |
| mem_rdata | input | 32 | Read data, valid with `mem_rvalid` |
| mem_rvalid | input | 1 | Read answered this cycle |
| out_valid | output | 1 | Instruction available |
| out_ready | input | 1 | Decode accepts instruction |
| out_instr | output | 32 | Instruction, upper half zero if compressed |
| out_pc | output | PC_W | Address of the instruction |
| out_is16 | output | 1 | Instruction is compressed |

## Verification
Some properties are checked by assertions on every cycle. These are: PC evenness, word alignment of requests, no request while stalled or while a buffered compressed instruction is issued, no output on a half-read split instruction, and the length flag agreeing with the instruction bits. The same applies to stability under back-pressure and clearing on flush or redirect. The bench's scenarios cover the rest: the rebuilt contents of split instructions, the order of the stream across redirects and flushes with no lost or repeated instructions, and the extra cycle a split redirect target costs.

// File: rtl/fa_pkg.sv
package fa_pkg;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned WORD_W = 32;

  // where the next instruction's low halfword comes from
  typedef enum logic [1:0] {
    SRC_BUF_C     = 2'd0,  // buffered halfword is a whole compressed instruction
    SRC_BUF_SPLIT = 2'd1,  // buffered halfword is the low half of a 32-bit one
    SRC_MEM_LO    = 2'd2,  // lower half of the word at the PC
    SRC_MEM_HI    = 2'd3   // upper half of the word at the PC
  } fa_src_e;

  function automatic logic fa_short(input logic [1:0] lsb);
    return lsb != 2'b11;
  endfunction
endpackage

// File: rtl/fa_len_decode.sv
module fa_len_decode (
  input  logic [1:0] lsb,
  output logic       is16
);
  assign is16 = fa_pkg::fa_short(lsb);
endmodule

// File: rtl/fa_hw_buffer.sv
module fa_hw_buffer #(
  parameter int unsigned HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              load,
  input  logic [HALF_W-1:0] load_data,
  input  logic              hold,
  output logic              vld,
  output logic [HALF_W-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vld  <= 1'b0;
      data <= '0;
    end else if (clear) begin
      vld <= 1'b0;
    end else if (load) begin
      vld  <= 1'b1;
      data <= load_data;
    end
  end

  // R7 / R9: discarding empties the buffer
  p_clear_empties_r7: assert property (@(posedge clk) disable iff (rst)
    clear |=> !vld);

  // R8: a frozen fetch keeps the buffered halfword
  p_stall_keeps_buffer_r8: assert property (@(posedge clk) disable iff (rst)
    (hold && !clear) |=> ($stable(vld) && $stable(data)));
endmodule

// File: rtl/fa_fetch_ctrl.sv
module fa_fetch_ctrl #(
  parameter int unsigned          PC_W     = 32,
  parameter logic [PC_W-1:0]      RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stall,
  input  logic            flush,
  input  logic            redir_valid,
  input  logic [PC_W-1:0] redir_pc,
  input  logic            out_held,
  input  logic [PC_W-1:0] out_held_pc,
  input  logic            can_load,
  input  logic            buf_vld,
  input  logic [15:0]     buf_hw,
  input  logic [31:0]     mem_rdata,
  input  logic            mem_rvalid,
  output logic            mem_req,
  output logic [PC_W-1:0] mem_addr,
  output logic            cand_valid,
  output logic [31:0]     cand_instr,
  output logic            cand_is16,
  output logic [PC_W-1:0] cand_pc,
  output logic            buf_clear,
  output logic            buf_load,
  output logic [15:0]     buf_load_data,
  output logic            fetch_hold
);
  import fa_pkg::*;

  localparam int unsigned     HALVES     = WORD_W / HALF_W;
  localparam logic [PC_W-1:0] WORD_BYTES = PC_W'(WORD_W / 8);
  localparam logic [PC_W-1:0] HALF_BYTES = PC_W'(HALF_W / 8);

  logic [PC_W-1:0]   pc_q, pc_d, word_base, pc_step;
  logic [HALVES-1:0] half_is16;
  logic              buf_is16, mem_is16;
  fa_src_e           src;
  logic              need_mem, data_ok, go, issue, want_load;
  logic [15:0]       lo_hw;

  // length of each halfword of the returned word
  for (genvar g = 0; g < HALVES; g++) begin : g_half_len
    fa_len_decode u_len (
      .lsb  (mem_rdata[g*HALF_W +: 2]),
      .is16 (half_is16[g])
    );
  end

  fa_len_decode u_buf_len (
    .lsb  (buf_hw[1:0]),
    .is16 (buf_is16)
  );

  assign word_base  = {pc_q[PC_W-1:2], 2'b00};
  assign mem_is16   = half_is16[pc_q[1]];
  assign lo_hw      = pc_q[1] ? mem_rdata[31:16] : mem_rdata[15:0];
  assign fetch_hold = stall | flush | redir_valid;

  always_comb begin
    if (buf_vld) src = buf_is16 ? SRC_BUF_C : SRC_BUF_SPLIT;
    else         src = pc_q[1] ? SRC_MEM_HI : SRC_MEM_LO;
  end

  assign need_mem = (src != SRC_BUF_C);
  assign mem_addr = (src == SRC_BUF_SPLIT) ? (word_base + WORD_BYTES) : word_base;
  assign mem_req  = need_mem && !fetch_hold && can_load;
  assign data_ok  = !need_mem || mem_rvalid;
  assign go       = !fetch_hold && can_load && data_ok;

  always_comb begin
    issue         = 1'b1;
    want_load     = 1'b0;
    buf_load_data = mem_rdata[31:16];
    cand_instr    = '0;
    cand_is16     = 1'b1;
    pc_step       = HALF_BYTES;
    unique case (src)
      SRC_BUF_C: begin
        cand_instr = {16'h0000, buf_hw};
      end
      SRC_BUF_SPLIT: begin
        cand_instr = {mem_rdata[15:0], buf_hw};
        cand_is16  = 1'b0;
        pc_step    = WORD_BYTES;
        want_load  = 1'b1;
      end
      SRC_MEM_LO: begin
        if (mem_is16) begin
          cand_instr = {16'h0000, lo_hw};
          want_load  = 1'b1;
        end else begin
          cand_instr = mem_rdata;
          cand_is16  = 1'b0;
          pc_step    = WORD_BYTES;
        end
      end
      SRC_MEM_HI: begin
        if (mem_is16) begin
          cand_instr = {16'h0000, lo_hw};
        end else begin
          // only the low half of a split instruction is here
          issue     = 1'b0;
          want_load = 1'b1;
          pc_step   = '0;
        end
      end
      default: ;
    endcase
  end

  assign cand_valid = go && issue;
  assign cand_pc    = pc_q;
  assign buf_clear  = redir_valid || flush || (go && src == SRC_BUF_C);
  assign buf_load   = go && want_load && !buf_clear;

  always_comb begin
    if (redir_valid)  pc_d = redir_pc & ~PC_W'(1);
    else if (flush)   pc_d = out_held ? out_held_pc : pc_q;
    else if (go)      pc_d = pc_q + pc_step;
    else              pc_d = pc_q;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_PC & ~PC_W'(1);
    else     pc_q <= pc_d;
  end

  // R3: the fetch PC never becomes odd
  p_pc_even_r3: assert property (@(posedge clk) disable iff (rst)
    !pc_q[0]);

  // R8: no read and no PC movement while stalled
  p_no_fetch_stalled_r8: assert property (@(posedge clk) disable iff (rst)
    stall |-> !mem_req);
  p_stall_holds_pc_r8: assert property (@(posedge clk) disable iff (rst)
    (stall && !flush && !redir_valid) |=> $stable(pc_q));

  // R11: reads are word aligned
  p_word_aligned_r11: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  // R4: a buffered compressed instruction needs no read
  p_buffer_no_read_r4: assert property (@(posedge clk) disable iff (rst)
    (buf_vld && buf_is16) |-> !mem_req);

  // R12: a half-read split instruction is not issued
  p_split_half_no_issue_r12: assert property (@(posedge clk) disable iff (rst)
    (!buf_vld && pc_q[1] && !mem_is16) |-> !cand_valid);

  // R7: the PC lands on the redirect target
  p_redirect_pc_r7: assert property (@(posedge clk) disable iff (rst)
    redir_valid |=> (pc_q == ($past(redir_pc) & ~PC_W'(1))));
endmodule

// File: rtl/fa_out_stage.sv
module fa_out_stage #(
  parameter int unsigned PC_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            kill,
  input  logic            load,
  input  logic [31:0]     in_instr,
  input  logic [PC_W-1:0] in_pc,
  input  logic            in_is16,
  input  logic            ready,
  output logic            can_load,
  output logic            vld_q,
  output logic [31:0]     instr_q,
  output logic [PC_W-1:0] pc_q,
  output logic            is16_q
);
  assign can_load = !vld_q || ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q   <= 1'b0;
      instr_q <= '0;
      pc_q    <= '0;
      is16_q  <= 1'b0;
    end else if (kill) begin
      vld_q <= 1'b0;
    end else if (load) begin
      vld_q   <= 1'b1;
      instr_q <= in_instr;
      pc_q    <= in_pc;
      is16_q  <= in_is16;
    end else if (vld_q && ready) begin
      vld_q <= 1'b0;
    end
  end

  // R10: a held instruction stays put under back-pressure
  p_hold_stable_r10: assert property (@(posedge clk) disable iff (rst)
    (vld_q && !ready && !kill) |=>
      (vld_q && $stable(instr_q) && $stable(pc_q) && $stable(is16_q)));

  // R9: discarding empties the output register
  p_kill_empties_r9: assert property (@(posedge clk) disable iff (rst)
    kill |=> !vld_q);
endmodule

// File: rtl/fetch_aligner.sv
module fetch_aligner #(
  parameter int unsigned     PC_W     = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stall,
  input  logic            flush,
  input  logic            redir_valid,
  input  logic [PC_W-1:0] redir_pc,
  output logic            mem_req,
  output logic [PC_W-1:0] mem_addr,
  input  logic [31:0]     mem_rdata,
  input  logic            mem_rvalid,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [31:0]     out_instr,
  output logic [PC_W-1:0] out_pc,
  output logic            out_is16
);
  logic            buf_vld, buf_clear, buf_load, fetch_hold;
  logic [15:0]     buf_hw, buf_load_data;
  logic            can_load, ov_q, cand_valid, cand_is16;
  logic [31:0]     cand_instr;
  logic [PC_W-1:0] cand_pc;
  logic            kill;

  assign kill = flush | redir_valid;

  fa_hw_buffer #(.HALF_W(16)) u_buf (
    .clk       (clk),
    .rst       (rst),
    .clear     (buf_clear),
    .load      (buf_load),
    .load_data (buf_load_data),
    .hold      (fetch_hold),
    .vld       (buf_vld),
    .data      (buf_hw)
  );

  fa_fetch_ctrl #(.PC_W(PC_W), .RESET_PC(RESET_PC)) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .stall         (stall),
    .flush         (flush),
    .redir_valid   (redir_valid),
    .redir_pc      (redir_pc),
    .out_held      (ov_q),
    .out_held_pc   (out_pc),
    .can_load      (can_load),
    .buf_vld       (buf_vld),
    .buf_hw        (buf_hw),
    .mem_rdata     (mem_rdata),
    .mem_rvalid    (mem_rvalid),
    .mem_req       (mem_req),
    .mem_addr      (mem_addr),
    .cand_valid    (cand_valid),
    .cand_instr    (cand_instr),
    .cand_is16     (cand_is16),
    .cand_pc       (cand_pc),
    .buf_clear     (buf_clear),
    .buf_load      (buf_load),
    .buf_load_data (buf_load_data),
    .fetch_hold    (fetch_hold)
  );

  fa_out_stage #(.PC_W(PC_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .kill     (kill),
    .load     (cand_valid),
    .in_instr (cand_instr),
    .in_pc    (cand_pc),
    .in_is16  (cand_is16),
    .ready    (out_ready),
    .can_load (can_load),
    .vld_q    (ov_q),
    .instr_q  (out_instr),
    .pc_q     (out_pc),
    .is16_q   (out_is16)
  );

  // R9: nothing is offered while a flush or redirect is in progress
  assign out_valid = ov_q && !kill;

  // R2: length flag agrees with the instruction bits
  p_len_flag_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_is16 == (out_instr[1:0] != 2'b11)));
  p_short_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_is16) |-> (out_instr[31:16] == 16'h0000));
endmodule

// File: tb/tb_fetch_aligner.sv
`timescale 1ns/1ps
module tb_fetch_aligner;
  localparam int PC_W  = 32;
  localparam int DEPTH = 64;

  logic clk = 1'b0, rst = 1'b1;
  logic stall = 0, flush = 0, redir_valid = 0, out_ready = 0, rv_en = 0;
  logic [PC_W-1:0] redir_pc = '0;
  logic mem_req, mem_rvalid, out_valid, out_is16;
  logic [PC_W-1:0] mem_addr, out_pc;
  logic [31:0] mem_rdata, out_instr;
  logic [31:0] mem [DEPTH];

  int checks = 0, errors = 0, idle = 0, accepted = 0;
  logic [PC_W-1:0] exp_pc = '0;

  always #4 clk = ~clk;

  fetch_aligner #(.PC_W(PC_W)) dut (
    .clk(clk), .rst(rst), .stall(stall), .flush(flush),
    .redir_valid(redir_valid), .redir_pc(redir_pc),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_rvalid(mem_rvalid), .out_valid(out_valid), .out_ready(out_ready),
    .out_instr(out_instr), .out_pc(out_pc), .out_is16(out_is16)
  );

  assign mem_rvalid = mem_req && rv_en;
  assign mem_rdata  = mem[(mem_addr >> 2) % DEPTH];

  function automatic logic [15:0] hw_at(input logic [PC_W-1:0] a);
    logic [31:0] w;
    w = mem[(a >> 2) % DEPTH];
    return a[1] ? w[31:16] : w[15:0];
  endfunction

  function automatic logic exp_short(input logic [PC_W-1:0] a);
    logic [15:0] h;
    h = hw_at(a);
    return h[1:0] != 2'b11;
  endfunction

  function automatic logic [31:0] exp_instr(input logic [PC_W-1:0] a);
    if (exp_short(a)) return {16'h0000, hw_at(a)};
    return {hw_at(a + 2), hw_at(a)};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // one cycle: drive at the falling edge, then judge the transfer it sets up
  task automatic step(input bit rdy, input bit stl, input bit fl,
                      input bit rd, input logic [PC_W-1:0] tgt, input bit rv);
    string tag;
    @(negedge clk);
    out_ready = rdy; stall = stl; flush = fl; redir_valid = rd;
    redir_pc = tgt; rv_en = rv;
    #1;
    if (out_valid && out_ready) begin
      if (exp_short(exp_pc))  tag = "R2";
      else if (exp_pc[1])     tag = "R5";
      else                    tag = "R3";
      chk(out_pc == exp_pc, "R3", "pc", out_pc, exp_pc);
      chk(out_instr == exp_instr(exp_pc), tag, "instr", out_instr, exp_instr(exp_pc));
      chk(out_is16 == exp_short(exp_pc), "R2", "is16", out_is16, exp_short(exp_pc));
      exp_pc = exp_pc + (exp_short(exp_pc) ? 2 : 4);
      idle = 0;
      accepted++;
    end else begin
      idle++;
    end
    if (rd) exp_pc = tgt & ~32'd1;
    if (idle > 400) begin
      chk(1'b0, "R3", "watchdog progress", idle, 0);
      finish_sim();
    end
  endtask

  initial begin
    #(8 * 190000);
    chk(1'b0, "R3", "global watchdog", 0, 1);
    finish_sim();
  end

  initial begin
    logic [PC_W-1:0] hold_pc;
    logic [31:0] hold_in;
    int misses;
    void'($urandom(32'd2024));
    for (int i = 0; i < DEPTH; i++) mem[i] = $urandom;
    // directed program: C,C | C,S1lo | S1hi,S2lo | S2hi,S3lo | S3hi,C | A
    mem[0] = {16'h0512, 16'h4501};
    mem[1] = {16'h8593, 16'h8082};
    mem[2] = {16'h0613, 16'h00a5};
    mem[3] = {16'h4703, 16'h1234};
    mem[4] = {16'h9702, 16'h0ff0};
    mem[5] = 32'h00b50533;

    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    // R1: reset state and first request
    chk(out_valid == 1'b0, "R1", "valid after reset", out_valid, 0);
    chk(mem_req == 1'b1, "R1", "first request", mem_req, 1);
    chk(mem_addr == 0, "R1", "first address", mem_addr, 0);
    for (int i = 0; i < 3; i++) begin
      step(1, 0, 0, 0, 0, 0);
      chk(out_valid == 1'b0, "R11", "no output while unanswered", out_valid, 0);
    end

    // straight run through the directed program (R2 R3 R5 R6)
    for (int i = 0; i < 14; i++) step(1, 0, 0, 0, 0, 1);
    chk(accepted >= 8, "R6", "directed stream length", accepted, 8);

    // R4: second compressed of a word comes without a read
    step(1, 0, 0, 1, 32'h0, 1);
    step(1, 0, 0, 0, 0, 1);
    chk(mem_req && mem_addr == 0, "R4", "read of word 0", mem_addr, 0);
    step(1, 0, 0, 0, 0, 1);
    chk(mem_req == 1'b0, "R4", "no reread for buffered compressed", mem_req, 0);

    // R7 / R12: redirect to split target at 0xA
    step(1, 0, 0, 1, 32'hA, 1);
    step(1, 0, 0, 0, 0, 1);
    chk(out_valid == 0, "R12", "split target cycle 1", out_valid, 0);
    chk(mem_addr == 32'h8, "R11", "split first word", mem_addr, 32'h8);
    step(1, 0, 0, 0, 0, 1);
    chk(out_valid == 0, "R12", "split target cycle 2", out_valid, 0);
    chk(mem_addr == 32'hC, "R11", "split next word", mem_addr, 32'hC);
    step(1, 0, 0, 0, 0, 1);
    chk(out_valid && out_pc == 32'hA, "R7", "split target pc", out_pc, 32'hA);
    chk(out_instr == 32'h12340613, "R5", "split target instr", out_instr, 32'h12340613);

    // R7: redirect to compressed target at odd halfword 0x13 -> 0x12
    step(1, 0, 0, 1, 32'h13, 1);
    step(1, 0, 0, 0, 0, 1);
    chk(out_valid == 0, "R7", "compressed target cycle 1", out_valid, 0);
    step(1, 0, 0, 0, 0, 1);
    chk(out_valid && out_pc == 32'h12, "R7", "compressed target pc", out_pc, 32'h12);
    chk(out_instr == 32'h00009702, "R2", "compressed target instr", out_instr, 32'h9702);

    // R8: stall freezes fetch
    step(0, 0, 0, 1, 32'h0, 1);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 4; i++) begin
      step(1, 1, 0, 0, 0, 1);
      chk(mem_req == 1'b0, "R8", "no request while stalled", mem_req, 0);
    end
    chk(out_valid == 0, "R8", "drained and frozen", out_valid, 0);

    // R10: back-pressure keeps output stable
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 1);
    hold_pc = out_pc; hold_in = out_instr;
    for (int i = 0; i < 4; i++) begin
      step(0, 0, 0, 0, 0, 1);
      chk(out_valid && out_pc == hold_pc && out_instr == hold_in, "R10",
          "held output", {out_pc, out_instr}, {hold_pc, hold_in});
    end

    // R9: flush hides and clears output without losing instructions
    step(0, 0, 1, 0, 0, 1);
    chk(out_valid == 0, "R9", "valid during flush", out_valid, 0);
    step(0, 0, 0, 0, 0, 1);
    chk(out_valid == 0, "R9", "valid after flush", out_valid, 0);
    for (int i = 0; i < 10; i++) step(1, 0, 0, 0, 0, 1);

    // R11: wait states suppress output
    misses = 0;
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) begin
      step(1, 0, 0, 0, 0, 0);
      if (out_valid) misses++;
      chk(mem_addr[1:0] == 0, "R11", "aligned address", mem_addr, 0);
    end
    chk(misses == 0, "R11", "no output during waits", misses, 0);

    // constrained random mix
    for (int i = 0; i < 6000; i++) begin
      step(($urandom % 4) != 0, ($urandom % 20) == 0, ($urandom % 40) == 0,
           ($urandom % 50) == 0, ($urandom % 128) * 2, ($urandom % 5) != 0);
    end
    for (int i = 0; i < 20; i++) step(1, 0, 0, 0, 0, 1);
    chk(accepted > 2000, "R3", "random stream progress", accepted, 2000);
    finish_sim();
  end
endmodule